// File: doc/BRIEF.md
# Periodic Event and Pulse Generator

This block turns the carry pulses of a real-time clock into a single event signal for a host. One of four carry sources is chosen by a period selector: the carry into the 1/64-second digit, the seconds digit, the minutes digit or the hours digit. Each event is the moment of the real carry; no separate divider or period counter is used. The block drives the enable of an active-low open-drain output and a status flag. The flag reads 1 exactly while the pin is pulled low.

Two modes share the output. In interrupt mode an event latches the output low until software writes a clear. In waveform mode each event pulls the output low for one period of a 128 Hz enable, which is 7.8125 ms, and then the output releases by itself. This gives low duty cycles of 1/2, 1/128, 1/7680 and 1/460800 across the four periods. A mask bit keeps the output open. A clear command releases the output at once in either mode. While the flag is set, new events are dropped. A configuration write behaves like an event, so software clears the flag after changing the period or the mode.

Top module: `pig_event_gen`

## Requirements
- R1: After reset, `irq_flag` is 0 and `pull_low` is 0. Asserting reset while the flag is set returns both to 0.
- R2: `period_sel` value k (0 = 1/64 s, 1 = second, 2 = minute, 3 = hour) makes only `carry_in[k]` an event source. Pulses on the other carry bits leave the flag unchanged.
- R3: While `mask` is 1, the flag is forced to 0 from the next cycle on, and events and configuration writes do not set it.
- R4: With `irq_mode` = 1, an event in cycle N sets the flag from cycle N+1. The flag then stays 1 until a clear or a mask.
- R5: An event that occurs while the flag is 1 is dropped. It neither extends a pulse nor leaves a pending flag after a clear.
- R6: With `irq_mode` = 0, an event sets the flag. The flag falls in the cycle after the first `tick_128` strobe that comes strictly after the event cycle. A strobe in the event cycle itself does not end the pulse.
- R7: `flag_clr` = 1 makes the flag 0 in the next cycle in both modes. It wins over an event in the same cycle.
- R8: `cfg_wr` = 1 with `mask` = 0 and the flag at 0 sets the flag as an event would. In waveform mode that flag then self-releases like any pulse.
- R9: `pull_low` equals `irq_flag` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carry_in | input | NUM_SRC | One-cycle carry pulses, index 0 = 1/64 s, 1 = s, 2 = min, 3 = h |
| tick_128 | input | 1 | One-cycle strobe at 128 Hz |
| period_sel | input | SEL_W | Selects the carry source |
| mask | input | 1 | 1 keeps the output open and the flag clear |
| irq_mode | input | 1 | 1 = latched interrupt, 0 = self-clearing pulse |
| flag_clr | input | 1 | Software write of 0 to the flag |
| cfg_wr | input | 1 | Strobe for a write to the mode or period bits |
| pull_low | output | 1 | Enable of the open-drain low driver |
| irq_flag | output | 1 | Status flag, 1 while the output is low |

## Verification
The bench builds the block with its defaults: four carry sources and a pulse one 128 Hz period wide. The carry and 128 Hz inputs are driven as single-cycle strobes chosen by the bench, not derived from real time. This brings every period source, the alignment of an event with a tick, and the end of a pulse into reach within a few cycles. Collisions such as a clear together with an event, or an event during a live pulse, are placed in exact cycles, so the dropping rules are observed at the flag.

// File: rtl/pig_pkg.sv
package pig_pkg;

    typedef enum logic {
        MODE_WAVE = 1'b0,
        MODE_IRQ  = 1'b1
    } pig_mode_e;

    typedef struct packed {
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/pig_carry_sel.sv
module pig_carry_sel #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] carry_in,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               event_o
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = carry_in[g] && (sel_i == SEL_W'(g));
    end

    assign event_o = |hit;

endmodule

// File: rtl/pig_width_timer.sv
module pig_width_timer #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic cancel_i,
    input  logic wave_i,
    input  logic tick_i,
    output logic expire_o
);

    localparam int              CNT_W = (PULSE_TICKS < 2) ? 1 : $clog2(PULSE_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_TICKS - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = 1'b0;
        if (cancel_i || !wave_i) begin
            tmr_d.armed = 1'b0;
            tmr_d.cnt   = '0;
        end else if (arm_i) begin
            tmr_d.armed = 1'b1;
            tmr_d.cnt   = '0;
        end else if (tmr_q.armed && tick_i) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.armed = 1'b0;
                tmr_d.cnt   = '0;
                expire_o    = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R6
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.armed && !cancel_i && wave_i && !tick_i) |=> tmr_q.armed);

endmodule

// File: rtl/pig_flag_core.sv
module pig_flag_core
    import pig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic cfg_i,
    input  logic mask_i,
    input  logic clr_i,
    input  logic expire_i,
    output logic flag_o,
    output logic set_o,
    output logic drop_o
);

    flag_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        set_o  = 1'b0;
        drop_o = mask_i || clr_i;
        if (drop_o) begin
            st_d.flag = 1'b0;
        end else if (expire_i) begin
            st_d.flag = 1'b0;
        end else if (!st_q.flag && (event_i || cfg_i)) begin
            st_d.flag = 1'b1;
            set_o     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R3
    mask_forces_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> !flag_o);

    // R7
    clear_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);

endmodule

// File: rtl/pig_event_gen.sv
module pig_event_gen
    import pig_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int SEL_W       = $clog2(NUM_SRC),
    parameter int PULSE_TICKS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] carry_in,
    input  logic               tick_128,
    input  logic [SEL_W-1:0]   period_sel,
    input  logic               mask,
    input  logic               irq_mode,
    input  logic               flag_clr,
    input  logic               cfg_wr,
    output logic               pull_low,
    output logic               irq_flag
);

    logic      event_raw;
    logic      set_now;
    logic      drop_now;
    logic      expire;
    logic      flag;
    pig_mode_e mode;

    assign mode = pig_mode_e'(irq_mode);

    pig_carry_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
        .carry_in (carry_in),
        .sel_i    (period_sel),
        .event_o  (event_raw)
    );

    pig_flag_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (event_raw),
        .cfg_i    (cfg_wr),
        .mask_i   (mask),
        .clr_i    (flag_clr),
        .expire_i (expire),
        .flag_o   (flag),
        .set_o    (set_now),
        .drop_o   (drop_now)
    );

    pig_width_timer #(.PULSE_TICKS(PULSE_TICKS)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (set_now && (mode == MODE_WAVE)),
        .cancel_i (drop_now),
        .wave_i   (mode == MODE_WAVE),
        .tick_i   (tick_128),
        .expire_o (expire)
    );

    assign pull_low = flag;
    assign irq_flag = flag;

    // R8
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(event_raw || cfg_wr));

    // R4
    irq_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && mode == MODE_IRQ && !mask && !flag_clr) |=> irq_flag);

endmodule

// File: tb/pig_event_gen_tb.sv
module pig_event_gen_tb;

    typedef struct packed {
        logic [3:0] car;
        logic [1:0] sel;
        logic       msk;
        logic       mode;
        logic       tick;
        logic       clr;
        logic       cfg;
        logic       exp_flag;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        // interrupt mode: R2 R4 R5 R7 R3
        '{4'b0001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
        '{4'b0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
        '{4'b0001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},
        '{4'b0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{4'b0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
        '{4'b0010, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{4'b0010, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
        '{4'b0010, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{4'b0100, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
        '{4'b0000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
        '{4'b0100, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},
        '{4'b1000, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
        '{4'b0000, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        // waveform mode: R6 R5 R7 R8
        '{4'b0001, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6},
        '{4'b0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
        '{4'b0001, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},
        '{4'b0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
        '{4'b0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},
        '{4'b0010, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
        '{4'b0000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{4'b0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
        '{4'b0000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},
        '{4'b0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] carry_in = '0;
    logic       tick_128 = 1'b0;
    logic [1:0] period_sel = '0;
    logic       mask = 1'b0;
    logic       irq_mode = 1'b1;
    logic       flag_clr = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       pull_low;
    logic       irq_flag;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pig_event_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .carry_in   (carry_in),
        .tick_128   (tick_128),
        .period_sel (period_sel),
        .mask       (mask),
        .irq_mode   (irq_mode),
        .flag_clr   (flag_clr),
        .cfg_wr     (cfg_wr),
        .pull_low   (pull_low),
        .irq_flag   (irq_flag)
    );

    task automatic check(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    task automatic drive(input vec_t v);
        carry_in   = v.car;
        period_sel = v.sel;
        mask       = v.msk;
        irq_mode   = v.mode;
        tick_128   = v.tick;
        flag_clr   = v.clr;
        cfg_wr     = v.cfg;
    endtask

    task automatic idle();
        carry_in = '0; tick_128 = 0; flag_clr = 0; cfg_wr = 0; mask = 0;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flag after reset", irq_flag, 1'b0);
        check("R1 pull_low after reset", pull_low, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            checks++;
            if (irq_flag !== VEC[i].exp_flag) begin
                failures++;
                $display("FAIL R%0d row %0d flag actual=%0b expected=%0b",
                         VEC[i].req, i, irq_flag, VEC[i].exp_flag);
            end
            // R9: output tracks flag
            check("R9 pull_low vs flag", pull_low, irq_flag);
        end

        // R6: multi-cycle wait, pulse holds until a later tick
        idle();
        irq_mode = 1'b0;
        period_sel = 2'd3;
        carry_in = 4'b1000;
        @(negedge clk);
        carry_in = '0;
        repeat (5) @(negedge clk);
        check("R6 pulse held without tick", irq_flag, 1'b1);
        tick_128 = 1'b1;
        @(negedge clk);
        tick_128 = 1'b0;
        check("R6 pulse released after tick", irq_flag, 1'b0);

        // R4: mode interrupt ignores ticks
        irq_mode = 1'b1;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        tick_128 = 1'b1;
        @(negedge clk);
        tick_128 = 1'b0;
        check("R4 latched through tick", irq_flag, 1'b1);

        // R1: reset while flag set
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 flag cleared by reset", irq_flag, 1'b0);
        check("R1 pull_low cleared by reset", pull_low, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule